// File: doc/BRIEF.md
# Timer Input Capture Unit

This block records the value of an external free-running counter into a 16-bit capture register whenever a chosen edge appears on a trigger line. The trigger line is one of two inputs: a general pin or the output of an analog comparator. A control bit picks the input. The chosen input passes through a synchronizer. An optional digital noise filter comes next, and then an edge detector that looks for rising or falling edges. Each capture sets a flag that an interrupt controller can watch. Software clears the flag by writing a one to it.

The capture register also serves as the counter's TOP value in some waveform modes. While the block is in such a mode, it makes no captures, and software can load the register over an 8-bit bus. Software writes the high byte first into a temporary byte latch, and the low-byte write then updates all 16 bits at once. When software reads the register, reading the low byte copies the current high byte into that same latch, so the high byte read afterwards belongs with the low byte. The block has no overrun protection: each capture overwrites the register.

Top module: `tcap_unit`

## Requirements
- R1: `src_sel`=0 selects `pin_in` and `src_sel`=1 selects `cmp_in`. Activity on the input that is not selected never causes a capture.
- R2: `edge_sel`=1 captures on a rising edge of the conditioned trigger and `edge_sel`=0 on a falling edge. The opposite edge causes no capture.
- R3: With the filter off, a trigger level first sampled at clock edge E0 loads `cap_val` with the `cnt_val` present at edge E0+2. `cap_flag` is set on that same edge.
- R4: With `filt_en`=1, the trigger level reaches the edge detector only after four consecutive samples at the new level. A level held for fewer than four cycles causes no capture. A capture that passes the filter lands exactly four cycles later than in R3.
- R5: Changing `src_sel` while the two inputs sit at different levels can produce a capture, and the block does not suppress it.
- R6: While `top_mode`=1 no capture occurs. `cap_flag` does not rise, and `cap_val` changes only through a bus low-byte write.
- R7: A bus write with `bus_hi`=1 stores `bus_wdata` in the temporary latch. A write with `bus_hi`=0 while `top_mode`=1 sets `cap_val` to {latch, `bus_wdata`}. A write with `bus_hi`=0 while `top_mode`=0 leaves `cap_val` unchanged.
- R8: `bus_rdata` shows `cap_val[7:0]` when `bus_hi`=0 and shows the latch when `bus_hi`=1. A read with `bus_hi`=0 copies `cap_val[15:8]` into the latch.
- R9: A new capture overwrites `cap_val` even if software has not read the previous value.
- R10: A one on `flag_clr` clears `cap_flag` on the next edge. If a capture happens in the same cycle, the flag stays set.
- R11: After reset, `cap_val`, the latch and `cap_flag` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the filter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_val | input | 16 | Current value of the external counter |
| pin_in | input | 1 | External capture pin |
| cmp_in | input | 1 | Comparator output |
| src_sel | input | 1 | Trigger source: 0 pin, 1 comparator |
| edge_sel | input | 1 | Active edge: 1 rising, 0 falling |
| filt_en | input | 1 | Enables the four-sample noise filter |
| top_mode | input | 1 | Waveform mode uses the capture register as TOP |
| flag_clr | input | 1 | Write-one-to-clear strobe for the capture flag |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_hi | input | 1 | Byte select: 1 high byte, 0 low byte |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Bus read data |
| cap_flag | output | 1 | Capture flag for the interrupt |
| cap_val | output | 16 | Capture register, also the TOP value |

## Verification
The assertions check four things on every cycle. Each capture event loads the counter value and sets the flag. TOP mode blocks captures and freezes the register except during a committing low-byte write. That write merges the latch with the bus byte. The flag obeys its clear and set-wins rules. Only the bench scenarios can show the rest. These are the exact two-cycle and six-cycle latencies from a pin change, the rejection of pulses shorter than four samples, the way the unused source and the inactive edge are ignored, the capture caused by switching sources, and the byte-consistent readback through the latch.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
   typedef enum logic {
      TRIG_PIN = 1'b0,
      TRIG_CMP = 1'b1
   } trig_src_e;

   typedef enum logic {
      EDGE_FALL = 1'b0,
      EDGE_RISE = 1'b1
   } trig_edge_e;
endpackage

// File: rtl/tcap_sync.sv
module tcap_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] chain_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= 1'b0;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/tcap_filter.sv
module tcap_filter #(
   parameter int SAMPLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   input  logic din,
   output logic dout
);
   generate
      if (SAMPLES > 1) begin : g_window
         localparam int HIST_W = SAMPLES - 1;
         logic [HIST_W-1:0]  hist_q;
         logic [SAMPLES-1:0] window;
         logic               level_q;

         assign window = {hist_q, din};

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hist_q  <= '0;
               level_q <= 1'b0;
            end else if (!hold) begin
               hist_q <= window[HIST_W-1:0];
               if (&window)        level_q <= 1'b1;
               else if (~|window)  level_q <= 1'b0;
            end
         end
         assign dout = level_q;
      end else begin : g_bypass
         assign dout = din;
      end
   endgenerate
endmodule

// File: rtl/tcap_edge.sv
module tcap_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   input  logic rise_sel,
   input  logic din,
   output logic hit
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     prev_q <= 1'b0;
      else if (!hold) prev_q <= din;
   end

   assign hit = !hold && (rise_sel ? (din && !prev_q) : (!din && prev_q));
endmodule

// File: rtl/tcap_unit.sv
module tcap_unit #(
   parameter int CNT_W        = 16,
   parameter int BYTE_W       = 8,
   parameter int SYNC_STAGES  = 2,
   parameter int FILT_SAMPLES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  cnt_val,
   input  logic              pin_in,
   input  logic              cmp_in,
   input  logic              src_sel,
   input  logic              edge_sel,
   input  logic              filt_en,
   input  logic              top_mode,
   input  logic              flag_clr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic              bus_hi,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   output logic              cap_flag,
   output logic [CNT_W-1:0]  cap_val
);
   import tcap_pkg::*;

   localparam int HI_LSB = BYTE_W;

   generate
      if (CNT_W != 2 * BYTE_W) begin : g_bad_width
         $error("tcap_unit: CNT_W must be twice BYTE_W");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("tcap_unit: SYNC_STAGES must be at least 2");
      end
      if (FILT_SAMPLES < 2) begin : g_bad_filt
         $error("tcap_unit: FILT_SAMPLES must be at least 2");
      end
   endgenerate

   trig_src_e  src_e;
   trig_edge_e edge_e;
   logic       trig_raw, trig_sync, trig_filt, trig_det, raw_hit, cap_evt;
   logic [CNT_W-1:0]  cap_q;
   logic [BYTE_W-1:0] tmp_q;
   logic              flag_q;
   logic              low_wr, low_rd;

   assign src_e    = trig_src_e'(src_sel);
   assign edge_e   = trig_edge_e'(edge_sel);
   assign trig_raw = (src_e == TRIG_CMP) ? cmp_in : pin_in;

   tcap_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (trig_raw),
      .dout (trig_sync)
   );

   tcap_filter #(.SAMPLES(FILT_SAMPLES)) i_filter (
      .clk  (clk),
      .rst_n(rst_n),
      .hold (top_mode),
      .din  (trig_sync),
      .dout (trig_filt)
   );

   assign trig_det = filt_en ? trig_filt : trig_sync;

   tcap_edge i_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .hold    (top_mode),
      .rise_sel(edge_e == EDGE_RISE),
      .din     (trig_det),
      .hit     (raw_hit)
   );

   assign cap_evt = raw_hit && !top_mode;
   assign low_wr  = bus_wr && !bus_hi;
   assign low_rd  = bus_rd && !bus_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cap_q <= '0;
      else if (cap_evt)          cap_q <= cnt_val;
      else if (top_mode && low_wr) cap_q <= {tmp_q, bus_wdata};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 tmp_q <= '0;
      else if (bus_wr && bus_hi)  tmp_q <= bus_wdata;
      else if (low_rd)            tmp_q <= cap_q[CNT_W-1:HI_LSB];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q <= 1'b0;
      else if (cap_evt)  flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
   end

   assign bus_rdata = bus_hi ? tmp_q : cap_q[BYTE_W-1:0];
   assign cap_flag  = flag_q;
   assign cap_val   = cap_q;
endmodule

// File: rtl/tcap_chk.sv
module tcap_chk #(
   parameter int CNT_W  = 16,
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CNT_W-1:0]  cnt_val,
   input logic              top_mode,
   input logic              flag_clr,
   input logic              bus_wr,
   input logic              bus_hi,
   input logic [BYTE_W-1:0] bus_wdata,
   input logic              cap_flag,
   input logic [CNT_W-1:0]  cap_val,
   input logic              cap_evt,
   input logic [BYTE_W-1:0] tmp_q
);
   assert_capture_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt |=> cap_flag && (cap_val == $past(cnt_val)));

   assert_top_no_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      top_mode |=> !$rose(cap_flag));

   assert_top_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (top_mode && !(bus_wr && !bus_hi)) |=> $stable(cap_val));

   assert_top_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (top_mode && bus_wr && !bus_hi) |=> cap_val == {$past(tmp_q), $past(bus_wdata)});

   assert_low_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!top_mode && !cap_evt) |=> $stable(cap_val));

   assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !cap_evt) |=> !cap_flag);

   assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && cap_evt) |=> cap_flag);
endmodule

bind tcap_unit tcap_chk #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) i_tcap_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cnt_val  (cnt_val),
   .top_mode (top_mode),
   .flag_clr (flag_clr),
   .bus_wr   (bus_wr),
   .bus_hi   (bus_hi),
   .bus_wdata(bus_wdata),
   .cap_flag (cap_flag),
   .cap_val  (cap_val),
   .cap_evt  (cap_evt),
   .tmp_q    (tmp_q)
);

// File: tb/test_tcap_unit.sv
module test_tcap_unit;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 8;
   // vector bits: [7] src, [6] rising, [5] filter, [4] capture expected, [3:0] pulse length
   localparam logic [7:0] VEC [NVEC] = '{
      8'b0_1_0_1_0001, 8'b0_0_0_1_0010, 8'b1_1_0_1_0001, 8'b1_0_0_1_0011,
      8'b0_1_1_1_0100, 8'b0_1_1_0_0011, 8'b1_0_1_1_0101, 8'b1_1_1_0_0010
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cnt;
   logic        pin_in = 1'b0, cmp_in = 1'b0, src_sel = 1'b0, edge_sel = 1'b1;
   logic        filt_en = 1'b0, top_mode = 1'b0, flag_clr = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_hi = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        cap_flag;
   logic [15:0] cap_val;
   int          checks = 0;
   int          errors = 0;
   logic        done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt + 16'd1;
   end

   tcap_unit i_tcap_unit (
      .clk(clk), .rst_n(rst_n), .cnt_val(cnt), .pin_in(pin_in), .cmp_in(cmp_in),
      .src_sel(src_sel), .edge_sel(edge_sel), .filt_en(filt_en), .top_mode(top_mode),
      .flag_clr(flag_clr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_hi(bus_hi),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_flag(cap_flag), .cap_val(cap_val)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(input logic on_cmp, input logic lvl, input int len,
                        output logic [15:0] c);
      @(negedge clk);
      if (on_cmp) cmp_in = lvl; else pin_in = lvl;
      c = cnt;
      repeat (len) @(negedge clk);
      if (on_cmp) cmp_in = ~lvl; else pin_in = ~lvl;
   endtask

   task automatic clear_flag;
      @(negedge clk); flag_clr = 1'b1;
      @(negedge clk); flag_clr = 1'b0;
   endtask

   task automatic bus_write(input logic hi, input logic [7:0] d);
      @(negedge clk); bus_wr = 1'b1; bus_hi = hi; bus_wdata = d;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic hi, output logic [7:0] d);
      @(negedge clk); bus_rd = 1'b1; bus_hi = hi;
      #1 d = bus_rdata;
      @(negedge clk); bus_rd = 1'b0;
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog R1..all actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [15:0] c, c2, prev;
      logic [7:0]  rd;
      logic        act_lvl;
      int          lat;

      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(1);
      // R11 reset state
      chk("R11 flag", cap_flag, 0);
      chk("R11 cap", cap_val, 0);
      bus_read(1'b1, rd);
      chk("R11 latch", rd, 0);

      // table walk: R1, R2, R3, R4
      for (int v = 0; v < NVEC; v++) begin
         src_sel  = VEC[v][7];
         edge_sel = VEC[v][6];
         filt_en  = VEC[v][5];
         act_lvl  = VEC[v][6];
         pin_in   = ~act_lvl;
         cmp_in   = ~act_lvl;
         lat      = VEC[v][5] ? 6 : 2;
         wait_cyc(10);
         clear_flag();
         wait_cyc(2);
         prev = cap_val;
         pulse(~VEC[v][7], act_lvl, 6, c);
         wait_cyc(12);
         chk($sformatf("R1 unused source vec%0d", v), cap_flag, 0);
         chk($sformatf("R1 unused source cap vec%0d", v), cap_val, prev);
         pulse(VEC[v][7], act_lvl, int'(VEC[v][3:0]), c);
         wait_cyc(12);
         chk($sformatf("R2 R4 flag vec%0d", v), cap_flag, VEC[v][4]);
         if (VEC[v][4])
            chk($sformatf("R3 R4 value vec%0d", v), cap_val, c + 16'(lat));
         else
            chk($sformatf("R4 rejected pulse vec%0d", v), cap_val, prev);
      end

      // R9 overwrite without read
      src_sel = 1'b0; edge_sel = 1'b1; filt_en = 1'b0;
      pin_in = 1'b0; cmp_in = 1'b0;
      wait_cyc(10);
      pulse(1'b0, 1'b1, 2, c);
      wait_cyc(6);
      pulse(1'b0, 1'b1, 2, c2);
      wait_cyc(6);
      chk("R9 overwrite", cap_val, c2 + 16'd2);

      // R10 clear and set-wins
      chk("R10 flag before clear", cap_flag, 1);
      clear_flag();
      #1 chk("R10 cleared", cap_flag, 0);
      pulse(1'b0, 1'b1, 2, c);
      wait_cyc(6);
      chk("R10 set again", cap_flag, 1);
      @(negedge clk); pin_in = 1'b1; c = cnt;   // first sampled at E0
      @(negedge clk);                            // after E0
      @(negedge clk); flag_clr = 1'b1;           // after E1, capture at E2
      @(negedge clk); flag_clr = 1'b0;
      chk("R10 set wins", cap_flag, 1);
      chk("R10 R3 value", cap_val, c + 16'd2);
      pin_in = 1'b0;
      wait_cyc(6);

      // R5 source switch
      edge_sel = 1'b1; src_sel = 1'b0; pin_in = 1'b0; cmp_in = 1'b1;
      wait_cyc(8);
      clear_flag();
      wait_cyc(2);
      chk("R5 idle", cap_flag, 0);
      @(negedge clk); src_sel = 1'b1;
      wait_cyc(6);
      chk("R5 switch capture", cap_flag, 1);
      src_sel = 1'b0; cmp_in = 1'b0;
      wait_cyc(8);

      // R6, R7 TOP mode
      clear_flag();
      @(negedge clk); top_mode = 1'b1;
      bus_write(1'b1, 8'h12);
      bus_write(1'b0, 8'hAB);
      chk("R7 commit", cap_val, 16'h12AB);
      pulse(1'b0, 1'b1, 3, c);
      wait_cyc(12);
      chk("R6 no flag", cap_flag, 0);
      chk("R6 cap hold", cap_val, 16'h12AB);

      // R8 consistent readback
      bus_read(1'b0, rd);
      chk("R8 low read", rd, 8'hAB);
      @(negedge clk); top_mode = 1'b0;
      wait_cyc(4);
      pulse(1'b0, 1'b1, 2, c);
      wait_cyc(8);
      chk("R8 R3 new capture", cap_val, c + 16'd2);
      bus_read(1'b1, rd);
      chk("R8 latched high", rd, 8'h12);
      c2 = c + 16'd2;
      bus_read(1'b0, rd);
      chk("R8 low new", rd, c2[7:0]);
      bus_read(1'b1, rd);
      chk("R8 high new", rd, c2[15:8]);

      // R7 low write outside TOP mode is ignored
      bus_write(1'b0, 8'h55);
      wait_cyc(1);
      chk("R7 ignored write", cap_val, c2);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule